// File: doc/BRIEF.md
# Microcoded Shared-Bus Four-Bit Adder

A small datapath adds two 4-bit numbers, one register transfer per clock, under a 9-bit microcode word. A single registered 4-bit bus carries every transfer. The sources that can load the bus are an input buffer, which presents the `din` switches, and the ALU result. Three clocked holding registers sit on the bus: two operand registers feed the ALU, and a third holds the result and presents it on `result`. An external 4-bit step selector picks one word from a fixed control store. That word says which source loads the bus, which holding register captures it, and which holding-register outputs are enabled.

To add two numbers, the operator walks the step selector through this sequence: load A, capture A, load B, capture B, sum, capture result, show. Between steps, `din` is set to each operand in turn and `alu_fn` is set to the wanted operation. The step codes are the control states of the block. Each step code is decoded with no memory, and the "transition" from one step to the next is the operator changing `step_sel`.

Top module: `mbadd_top`

Control word bit layout, from bit 0 upward:
- `in_oe`: input buffer drives the bus source.
- `bus_we1`: bus loads from the input buffer.
- `bus_we2`: bus loads from the ALU.
- `lat1_gate` and `lat1_oe_n`: capture enable and active-low output enable of operand register 1.
- `lat2_gate` and `lat2_oe_n`: the same pair for operand register 2.
- `lat3_gate` and `lat3_oe_n`: the same pair for the result register.

Control states (value of `step_sel`) and their words:

| Code | State | What the word does |
|------|-------|--------------------|
| 0 | IDLE | No writes. All holding-register outputs are disabled. |
| 1 | LOAD_A | `in_oe` and `bus_we1` are set. |
| 2 | CAPT_A | `lat1_gate` is set. |
| 3 | LOAD_B | `in_oe` and `bus_we1` are set. |
| 4 | CAPT_B | `lat2_gate` is set. |
| 5 | SUM | `bus_we2` is set. Operand register outputs are enabled. |
| 6 | CAPT_R | `lat3_gate` is set. The result output is enabled. |
| 7 | SHOW | Only the result output is enabled. |
| 8 to 15 | unlisted | The word is all zero. |

## Requirements
- R1: Step codes 0 to 7 produce the control words in the state table above. Walking the steps LOAD_A, CAPT_A, LOAD_B, CAPT_B, SUM, CAPT_R, SHOW leaves `alu_fn(A, B)` on `result`.
- R2: Step codes 8 to 15 give an all-zero control word. No register is written, and the result output is enabled.
- R3: On a rising edge where `bus_we1` is set with `in_oe`, the bus register loads `din`. With neither bus write enable set, the bus register holds its value for any number of cycles.
- R4: A holding register captures the bus on a rising edge only while its gate bit is set. Otherwise it keeps its value.
- R5: While `lat3_oe_n` is 1, `result` reads 0. While `lat3_oe_n` is 0, `result` shows the result register.
- R6: `alu_fn` = 0 gives (A + B) mod 16, and the carry is dropped.
- R7: The other ALU codes are: 1 gives (A − B) mod 16, 2 gives A AND B, 3 gives A OR B, 4 gives A XOR B, 5 passes A, 6 passes B, 7 gives NOT A.
- R8: `alu_fn` codes 8 to 15 give a result of 0.
- R9: A synchronous `rst` clears the bus register and all three holding registers to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All registers update on its rising edge. |
| rst | input | 1 | Synchronous reset, active high. |
| din | input | 4 | Operand switches that the input buffer presents. |
| step_sel | input | 4 | Step selector that addresses the control store. |
| alu_fn | input | 4 | ALU function select. |
| result | output | 4 | Result register contents, gated by its output enable. |

## Verification
The assertions assume that `din`, `step_sel` and `alu_fn` are steady around each rising clock edge. They also assume that reset is synchronous and that a decoded word never sets both bus write enables in the same cycle. The bench changes all inputs on the falling edge only, and it uses only the listed step codes plus a few unlisted ones, so both write enables are never set together. Every check samples `result` shortly after a falling edge, once the registered path has settled.

// File: rtl/mbadd_pkg.sv
package mbadd_pkg;

    parameter int DATA_W = 4;
    parameter int SEL_W  = 4;
    parameter int FN_W   = 4;
    parameter int LAT_N  = 3;

    typedef struct packed {
        logic lat3_oe_n;
        logic lat3_gate;
        logic lat2_oe_n;
        logic lat2_gate;
        logic lat1_oe_n;
        logic lat1_gate;
        logic bus_we2;
        logic bus_we1;
        logic in_oe;
    } ctl_word_t;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_LOAD_A = 4'd1,
        ST_CAPT_A = 4'd2,
        ST_LOAD_B = 4'd3,
        ST_CAPT_B = 4'd4,
        ST_SUM    = 4'd5,
        ST_CAPT_R = 4'd6,
        ST_SHOW   = 4'd7
    } step_e;

    typedef enum logic [3:0] {
        FN_ADD   = 4'd0,
        FN_SUB   = 4'd1,
        FN_AND   = 4'd2,
        FN_OR    = 4'd3,
        FN_XOR   = 4'd4,
        FN_PASSA = 4'd5,
        FN_PASSB = 4'd6,
        FN_NOTA  = 4'd7
    } alu_fn_e;

endpackage

// File: rtl/mbadd_ctl_store.sv
module mbadd_ctl_store
    import mbadd_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic [SW-1:0] step_sel,
    output ctl_word_t     ctl
);

    localparam int LISTED = 8;

    // Baseline for every listed step: no writes, all outputs disabled.
    ctl_word_t quiet;
    always_comb begin
        quiet           = '0;
        quiet.lat1_oe_n = 1'b1;
        quiet.lat2_oe_n = 1'b1;
        quiet.lat3_oe_n = 1'b1;
    end

    always_comb begin
        ctl = '0;
        if (int'(step_sel) < LISTED) begin
            ctl = quiet;
            unique case (step_e'(step_sel[3:0]))
                ST_IDLE: begin
                end
                ST_LOAD_A, ST_LOAD_B: begin
                    ctl.in_oe   = 1'b1;
                    ctl.bus_we1 = 1'b1;
                end
                ST_CAPT_A: ctl.lat1_gate = 1'b1;
                ST_CAPT_B: ctl.lat2_gate = 1'b1;
                ST_SUM: begin
                    ctl.bus_we2   = 1'b1;
                    ctl.lat1_oe_n = 1'b0;
                    ctl.lat2_oe_n = 1'b0;
                end
                ST_CAPT_R: begin
                    ctl.lat3_gate = 1'b1;
                    ctl.lat3_oe_n = 1'b0;
                end
                ST_SHOW: ctl.lat3_oe_n = 1'b0;
                default: ctl = '0;
            endcase
        end
    end

endmodule

// File: rtl/mbadd_bus.sv
module mbadd_bus #(
    parameter int DW    = 4,
    parameter int N_SRC = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_SRC-1:0]           we,
    input  logic [N_SRC-1:0][DW-1:0]   src,
    output logic [DW-1:0]              bus_q
);

    logic [DW-1:0] bus_d;
    logic          any_we;

    // Lowest-numbered asserted source wins.
    always_comb begin
        bus_d  = bus_q;
        any_we = 1'b0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (we[i]) begin
                bus_d  = src[i];
                any_we = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q <= '0;
        end else if (any_we) begin
            bus_q <= bus_d;
        end
    end

endmodule

// File: rtl/mbadd_latch.sv
module mbadd_latch #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gate,
    input  logic          oe_n,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q,
    output logic [DW-1:0] y
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (gate) begin
            q <= d;
        end
    end

    always_comb begin
        y = oe_n ? '0 : q;
    end

endmodule

// File: rtl/mbadd_alu.sv
module mbadd_alu
    import mbadd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FW = FN_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [FW-1:0] fn,
    output logic [DW-1:0] f
);

    logic [DW:0] wide_sum;
    logic [DW:0] wide_dif;

    always_comb begin
        wide_sum = {1'b0, a} + {1'b0, b};
        wide_dif = {1'b0, a} - {1'b0, b};
        f = '0;
        case (fn)
            FN_ADD:   f = wide_sum[DW-1:0];
            FN_SUB:   f = wide_dif[DW-1:0];
            FN_AND:   f = a & b;
            FN_OR:    f = a | b;
            FN_XOR:   f = a ^ b;
            FN_PASSA: f = a;
            FN_PASSB: f = b;
            FN_NOTA:  f = ~a;
            default:  f = '0;
        endcase
    end

endmodule

// File: rtl/mbadd_top.sv
module mbadd_top
    import mbadd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = SEL_W,
    parameter int FW = FN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  logic [SW-1:0] step_sel,
    input  logic [FW-1:0] alu_fn,
    output logic [DW-1:0] result
);

    localparam int N_SRC = 2;
    localparam int N_LAT = LAT_N;

    ctl_word_t                  ctl;
    logic [DW-1:0]              in_drv;
    logic [DW-1:0]              alu_f;
    logic [DW-1:0]              bus_q;
    logic [N_SRC-1:0]           bus_we;
    logic [N_SRC-1:0][DW-1:0]   bus_src;
    logic [N_LAT-1:0]           lat_gate;
    logic [N_LAT-1:0]           lat_oe_n;
    logic [N_LAT-1:0][DW-1:0]   lat_q;
    logic [N_LAT-1:0][DW-1:0]   lat_y;

    mbadd_ctl_store #(.SW(SW)) u_store (
        .step_sel (step_sel),
        .ctl      (ctl)
    );

    // Input buffer: presents the switches only while enabled.
    always_comb begin
        in_drv = ctl.in_oe ? din : '0;
    end

    always_comb begin
        bus_we     = {ctl.bus_we2, ctl.bus_we1};
        bus_src[0] = in_drv;
        bus_src[1] = alu_f;
        lat_gate   = {ctl.lat3_gate, ctl.lat2_gate, ctl.lat1_gate};
        lat_oe_n   = {ctl.lat3_oe_n, ctl.lat2_oe_n, ctl.lat1_oe_n};
    end

    mbadd_bus #(.DW(DW), .N_SRC(N_SRC)) u_bus (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .src   (bus_src),
        .bus_q (bus_q)
    );

    for (genvar i = 0; i < N_LAT; i++) begin : g_lat
        mbadd_latch #(.DW(DW)) u_lat (
            .clk  (clk),
            .rst  (rst),
            .gate (lat_gate[i]),
            .oe_n (lat_oe_n[i]),
            .d    (bus_q),
            .q    (lat_q[i]),
            .y    (lat_y[i])
        );
    end

    mbadd_alu #(.DW(DW), .FW(FW)) u_alu (
        .a  (lat_y[0]),
        .b  (lat_y[1]),
        .fn (alu_fn),
        .f  (alu_f)
    );

    always_comb begin
        result = lat_y[N_LAT-1];
    end

endmodule

// File: rtl/mbadd_chk.sv
module mbadd_chk
    import mbadd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = SEL_W,
    parameter int FW = FN_W,
    parameter int NL = LAT_N
) (
    input logic                  clk,
    input logic                  rst,
    input logic [DW-1:0]         din,
    input logic [SW-1:0]         step_sel,
    input logic [FW-1:0]         alu_fn,
    input logic [DW-1:0]         result,
    input ctl_word_t             ctl,
    input logic [DW-1:0]         bus_q,
    input logic [NL-1:0][DW-1:0] lat_q
);

    p_unlisted_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (int'(step_sel) >= 8) |-> (ctl == '0));

    p_bus_load_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl.bus_we1 && ctl.in_oe) |=> (bus_q == $past(din)));

    p_bus_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!ctl.bus_we1 && !ctl.bus_we2) |=> (bus_q == $past(bus_q)));

    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.lat3_gate |=> (lat_q[NL-1] == $past(bus_q)));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !ctl.lat3_gate |=> (lat_q[NL-1] == $past(lat_q[NL-1])));

    p_result_off_r5: assert property (@(posedge clk) disable iff (rst)
        ctl.lat3_oe_n |-> (result == '0));

    p_sum_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl.bus_we2 && !ctl.bus_we1 && alu_fn == FN_ADD
         && !ctl.lat1_oe_n && !ctl.lat2_oe_n)
        |=> (bus_q == DW'($past(lat_q[0]) + $past(lat_q[1]))));

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (bus_q == '0 && lat_q == '0));

endmodule

bind mbadd_top mbadd_chk #(.DW(DW), .SW(SW), .FW(FW), .NL(N_LAT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .step_sel (step_sel),
    .alu_fn   (alu_fn),
    .result   (result),
    .ctl      (ctl),
    .bus_q    (bus_q),
    .lat_q    (lat_q)
);

// File: tb/mbadd_top_test.sv
module mbadd_top_test;

    localparam int  PERIOD   = 8;
    localparam int  WATCHDOG = 200000;
    localparam int  NVEC     = 12;
    // {a, b, fn, expected}
    localparam logic [15:0] VEC [NVEC] = '{
        16'h351E, 16'hCA28, 16'hC33F, 16'hF54A,
        16'h7257, 16'h7262, 16'h507A, 16'hF100,
        16'h9801, 16'h3480, 16'h34F0, 16'h011F
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] din = '0;
    logic [3:0] step_sel = '0;
    logic [3:0] alu_fn = '0;
    logic [3:0] result;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD / 2) clk = ~clk;

    mbadd_top uut (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .step_sel (step_sel),
        .alu_fn   (alu_fn),
        .result   (result)
    );

    task automatic apply(input logic [3:0] s, input logic [3:0] d);
        @(negedge clk);
        step_sel = s;
        din      = d;
    endtask

    task automatic check(input string req, input logic [3:0] exp);
        #1;
        checks++;
        if (result !== exp) begin
            fails++;
            $display("FAIL %s: result=%h expected=%h", req, result, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] a, input logic [3:0] b,
                          input logic [3:0] fn);
        alu_fn = fn;
        apply(4'd1, a);
        apply(4'd2, a);
        apply(4'd3, b);
        apply(4'd4, b);
        apply(4'd5, b);
        apply(4'd6, b);
        apply(4'd7, b);
    endtask

    initial begin
        #(PERIOD * WATCHDOG);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: registers cleared by reset, seen through an enabled output
        apply(4'd8, 4'd0);
        rst = 1'b0;
        check("R9 reset", 4'h0);

        // R1 R6: full sequence, every operand pair, add
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                run_op(4'(a), 4'(b), 4'd0);
                check("R1 R6 add", 4'(a + b));
            end
        end

        // R7 R8: vector table of the other functions
        for (int i = 0; i < NVEC; i++) begin
            run_op(VEC[i][15:12], VEC[i][11:8], VEC[i][7:4]);
            check(VEC[i][7:4] >= 4'd8 ? "R8 undefined fn" : "R7 fn", VEC[i][3:0]);
        end

        // R4: bus reload without a capture leaves the result register alone
        run_op(4'd3, 4'd4, 4'd0);
        apply(4'd1, 4'd6);
        apply(4'd7, 4'd6);
        check("R4 no capture", 4'h7);

        // R3: bus holds across idle steps, then is captured
        for (int k = 0; k < 3; k++) apply(4'd0, 4'd9);
        apply(4'd6, 4'd9);
        apply(4'd7, 4'd9);
        check("R3 bus hold", 4'h6);

        // R5: output disabled in IDLE
        apply(4'd0, 4'd9);
        check("R5 disabled", 4'h0);
        apply(4'd7, 4'd9);
        check("R5 enabled", 4'h6);

        // R2: unlisted steps write nothing and enable the output
        for (int k = 0; k < 3; k++) apply(4'd12, 4'd2);
        check("R2 unlisted", 4'h6);
        apply(4'd15, 4'd2);
        apply(4'd6, 4'd2);
        apply(4'd7, 4'd2);
        check("R2 no bus load", 4'h6);

        // R9: reset in mid-run clears bus and result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        step_sel = 4'd7;
        check("R9 result cleared", 4'h0);
        apply(4'd6, 4'd5);
        apply(4'd7, 4'd5);
        check("R9 bus cleared", 4'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule